// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock waveform of an I2C controller. It holds a high-period count and a low-period count for each of three speed classes: standard, fast and high speed. Fast mode and fast-mode-plus share one pair and differ only in the values that software loads. A two-bit speed field picks the active pair. The block drives the clock line low for the low count. It then releases the line and counts the high period only while the sampled line is actually high, so a target that holds the clock low simply lengthens the phase. An SDA-change strobe fires a programmable number of cycles after each falling edge. This tells the bit engine when it may move the data line.

Software loads the timing registers while the controller is disabled and then raises the enable. Writes that arrive while the block is enabled are dropped. When the build has no high-speed capability, the high-speed selection falls back to the fast pair. Counts below a floor of six cycles are raised to six so that both phases stay well formed.

Top module: `scl_timing_gen`

## Requirements
- R1: During and right after reset, `sclDriveLow`, `sclRiseStb`, `sclFallStb` and `sdaChgStb` are all 0. All seven timing registers reset to 0.
- R2: With `speedSel`=2'b01, the low phase uses the standard low count (register address 1) and the high phase uses the standard high count (address 0).
- R3: With `speedSel`=2'b10 or 2'b00, the fast pair is used: high count at address 2, low count at address 3.
- R4: With `speedSel`=2'b11 and `HS_PRESENT`=1, the high-speed pair is used: high count at address 4, low count at address 5. With `HS_PRESENT`=0, the same selection uses the fast pair.
- R5: A programmed count below 6 behaves as 6. After reset with no writes, the low phase lasts 6 cycles and the released phase lasts 7 cycles.
- R6: Each low phase drives `sclDriveLow`=1 for exactly the effective low count of cycles. `sclFallStb` is 1 in the first low cycle and only there.
- R7: After release, the high count advances only in cycles whose registered `sclIn` sample is 1. With `sclIn` following the line, the released phase lasts the effective high count plus 1 cycles. Each cycle that `sclIn` is held low after release adds one cycle. `sclRiseStb` is 1 in the first released cycle.
- R8: `sdaChgStb` pulses once per low phase, in low cycle index min(H, L-2). Index 0 is the first low cycle, H is the hold register (address 6) and L is the effective low count.
- R9: A register write (`cfgWe`=1, address `cfgAddr`, data `cfgData`) takes effect only while `ctrlEnable`=0. A write made while enabled leaves the waveform unchanged, both then and after a later disable and re-enable. Address 7 is unused.
- R10: Lowering `ctrlEnable` releases the line in the next cycle and keeps it released with no strobes. Raising `ctrlEnable` starts with a low phase in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Controller enable; timing writes only land while low |
| cfgWe | input | 1 | Timing register write strobe |
| cfgAddr | input | 3 | Register select: 0/1 std high/low, 2/3 fast high/low, 4/5 hs high/low, 6 SDA hold |
| cfgData | input | CNT_W | Write data |
| speedSel | input | 2 | Speed class: 01 standard, 10 fast, 11 high, 00 fast |
| sclIn | input | 1 | Observed SCL line level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sclRiseStb | output | 1 | Pulse in first released cycle of each high phase |
| sclFallStb | output | 1 | Pulse in first cycle of each low phase |
| sdaChgStb | output | 1 | Pulse marking when SDA may change |

## Verification
The bench measures phase widths at the ports in every speed class, including the unused code 00 and the high-speed code on a second instance built without high-speed support. A wrong pair mux or a missing fallback would show up as widths that belong to another register pair. Counts of 0 through 5 probe the clamp; without it, a phase would wrap through the whole count range or last one cycle. Holding `sclIn` low after release checks that the high phase stretches, so a design that counted free-running would release too early. A hold value beyond the low phase, writes attempted while enabled, and a disable in mid-phase would expose an SDA strobe outside the low phase, registers that can be corrupted at run time, or a line left driven low.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // command strobes from the phase sequencer to the count datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;

  localparam logic [2:0] ADDR_STD_HI  = 3'd0;
  localparam logic [2:0] ADDR_STD_LO  = 3'd1;
  localparam logic [2:0] ADDR_FST_HI  = 3'd2;
  localparam logic [2:0] ADDR_FST_LO  = 3'd3;
  localparam logic [2:0] ADDR_HS_HI   = 3'd4;
  localparam logic [2:0] ADDR_HS_LO   = 3'd5;
  localparam logic [2:0] ADDR_HOLD    = 3'd6;
  localparam int         NUM_TIM_REGS = 7;

endpackage

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_timing_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_CNT    = 6,
  parameter bit HS_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrlEnable,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic [1:0]       speedSel,
  input  logic             sclIn,
  input  cntCmd_t          cmd,
  output logic             lowDone,
  output logic             highDone,
  output logic             holdHit,
  output logic             sclSeen
);

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] timReg [NUM_TIM_REGS];
  logic [CNT_W-1:0] hiRaw, loRaw, effHigh, effLow, holdLim, holdEff;
  logic [CNT_W-1:0] phaseCnt;
  logic             useHs, useStd;
  logic             sclQ;

  // timing registers: writable only while the controller is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIM_REGS; i++) timReg[i] <= '0;
    end else if (cfgWe && !ctrlEnable && (cfgAddr < 3'(NUM_TIM_REGS))) begin
      timReg[cfgAddr] <= cfgData;
    end
  end

  // speed class decode; the high-speed pair exists only if built in
  generate
    if (HS_PRESENT) begin : g_hs
      assign useHs = (speedSel == 2'b11);
    end else begin : g_nohs
      assign useHs = 1'b0;
    end
  endgenerate

  assign useStd = (speedSel == 2'b01);

  always_comb begin
    if (useHs) begin
      hiRaw = timReg[ADDR_HS_HI];
      loRaw = timReg[ADDR_HS_LO];
    end else if (useStd) begin
      hiRaw = timReg[ADDR_STD_HI];
      loRaw = timReg[ADDR_STD_LO];
    end else begin
      hiRaw = timReg[ADDR_FST_HI];
      loRaw = timReg[ADDR_FST_LO];
    end
  end

  // floor clamp keeps each phase long enough to be well formed
  assign effHigh = (hiRaw < FLOOR) ? FLOOR : hiRaw;
  assign effLow  = (loRaw < FLOOR) ? FLOOR : loRaw;

  // SDA change point stays inside the low phase
  assign holdLim = effLow - CNT_W'(2);
  assign holdEff = (timReg[ADDR_HOLD] > holdLim) ? holdLim : timReg[ADDR_HOLD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclQ <= 1'b0;
    else        sclQ <= sclIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phaseCnt <= '0;
    else if (cmd.cntClr) phaseCnt <= '0;
    else if (cmd.cntInc) phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign sclSeen  = sclQ;
  assign lowDone  = (phaseCnt == effLow - CNT_W'(1));
  assign highDone = sclQ && (phaseCnt == effHigh - CNT_W'(1));
  assign holdHit  = (phaseCnt == holdEff);

endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
  import scl_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctrlEnable,
  input  logic    lowDone,
  input  logic    highDone,
  input  logic    holdHit,
  input  logic    sclSeen,
  output cntCmd_t cmd,
  output logic    sclDriveLow,
  output logic    sclRiseStb,
  output logic    sclFallStb,
  output logic    sdaChgStb
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (!ctrlEnable) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_LOW;
        PH_LOW:  if (lowDone)  phaseNext = PH_HIGH;
        PH_HIGH: if (highDone) phaseNext = PH_LOW;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sclRiseStb <= 1'b0;
      sclFallStb <= 1'b0;
    end else begin
      phase      <= phaseNext;
      sclRiseStb <= (phase == PH_LOW)  && (phaseNext == PH_HIGH);
      sclFallStb <= (phase != PH_LOW)  && (phaseNext == PH_LOW);
    end
  end

  assign cmd.cntClr = (phaseNext != phase) || (phase == PH_IDLE);
  assign cmd.cntInc = (phase == PH_LOW) || ((phase == PH_HIGH) && sclSeen);

  assign sclDriveLow = (phase == PH_LOW);
  assign sdaChgStb   = (phase == PH_LOW) && holdHit;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_CNT    = 6,
  parameter bit HS_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrlEnable,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic [1:0]       speedSel,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sclRiseStb,
  output logic             sclFallStb,
  output logic             sdaChgStb
);

  cntCmd_t cmd;
  logic    lowDone, highDone, holdHit, sclSeen;

  scl_timing_dp #(
    .CNT_W     (CNT_W),
    .MIN_CNT   (MIN_CNT),
    .HS_PRESENT(HS_PRESENT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrlEnable(ctrlEnable),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .speedSel  (speedSel),
    .sclIn     (sclIn),
    .cmd       (cmd),
    .lowDone   (lowDone),
    .highDone  (highDone),
    .holdHit   (holdHit),
    .sclSeen   (sclSeen)
  );

  scl_timing_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlEnable (ctrlEnable),
    .lowDone    (lowDone),
    .highDone   (highDone),
    .holdHit    (holdHit),
    .sclSeen    (sclSeen),
    .cmd        (cmd),
    .sclDriveLow(sclDriveLow),
    .sclRiseStb (sclRiseStb),
    .sclFallStb (sclFallStb),
    .sdaChgStb  (sdaChgStb)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ctrlEnable,
  input logic sclDriveLow,
  input logic sclRiseStb,
  input logic sclFallStb,
  input logic sdaChgStb
);

  logic [CNT_W:0] lowRun;

  // length of the current low run, used for the floor check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lowRun <= '0;
    else if (sclDriveLow) lowRun <= lowRun + (CNT_W+1)'(1);
    else                  lowRun <= '0;
  end

  AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclDriveLow) && $past(ctrlEnable)) |-> (lowRun >= (CNT_W+1)'(MIN_CNT))); // R5

  AST_FALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclDriveLow) |-> sclFallStb); // R6

  AST_FALL_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sclFallStb |-> sclDriveLow); // R6

  AST_RISE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclDriveLow) && $past(ctrlEnable)) |-> sclRiseStb); // R7

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclRiseStb, sclFallStb})); // R7

  AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdaChgStb |-> sclDriveLow); // R8

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |=> (!sclDriveLow && !sdaChgStb)); // R10

endmodule

bind scl_timing_gen scl_timing_chk #(
  .CNT_W  (CNT_W),
  .MIN_CNT(MIN_CNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrlEnable (ctrlEnable),
  .sclDriveLow(sclDriveLow),
  .sclRiseStb (sclRiseStb),
  .sclFallStb (sclFallStb),
  .sdaChgStb  (sdaChgStb)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrlEnable = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [1:0]  speedSel = 2'b01;
  logic        holdLow = 1'b0;
  logic        useAlt = 1'b0;

  logic drvA, riseA, fallA, sdaA;
  logic drvB, riseB, fallB, sdaB;
  logic sclA, sclB;
  logic mDrive, mRise, mFall, mSda;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // mirror of programmed registers, used for expected values
  int regMirror [7];

  always #4 clk = ~clk; // 125 MHz

  assign sclA = !drvA && !holdLow;
  assign sclB = !drvB;

  assign mDrive = useAlt ? drvB  : drvA;
  assign mRise  = useAlt ? riseB : riseA;
  assign mFall  = useAlt ? fallB : fallA;
  assign mSda   = useAlt ? sdaB  : sdaA;

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrlEnable(ctrlEnable), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .speedSel(speedSel), .sclIn(sclA),
    .sclDriveLow(drvA), .sclRiseStb(riseA), .sclFallStb(fallA), .sdaChgStb(sdaA)
  );

  scl_timing_gen #(.HS_PRESENT(1'b0)) u_dutNoHs (
    .clk(clk), .rst_n(rst_n), .ctrlEnable(ctrlEnable), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .speedSel(speedSel), .sclIn(sclB),
    .sclDriveLow(drvB), .sclRiseStb(riseB), .sclFallStb(fallB), .sdaChgStb(sdaB)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v < 6) ? 6 : v;
  endfunction

  // index of the high count register for a speed code
  function automatic int pairBase(input logic [1:0] sel, input bit hs);
    if (sel == 2'b11 && hs) return 4;
    if (sel == 2'b01)       return 0;
    return 2;
  endfunction

  function automatic int expLow(input logic [1:0] sel, input bit hs);
    return eff(regMirror[pairBase(sel, hs) + 1]);
  endfunction

  function automatic int expHigh(input logic [1:0] sel, input bit hs, input int stretch);
    return eff(regMirror[pairBase(sel, hs)]) + 1 + stretch;
  endfunction

  function automatic int expSda(input logic [1:0] sel, input bit hs);
    int lim = expLow(sel, hs) - 2;
    return (regMirror[6] > lim) ? lim : regMirror[6];
  endfunction

  task automatic wrReg(input int addr, input int val, input bit track);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(addr); cfgData = 16'(val);
    @(negedge clk);
    cfgWe = 1'b0;
    if (track && addr < 7) regMirror[addr] = val;
  endtask

  task automatic turnOff();
    @(negedge clk); ctrlEnable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic turnOn();
    @(negedge clk); ctrlEnable = 1'b1;
  endtask

  task automatic measure(input bit alt, input int stretch,
                         output int lowW, output int highW, output int sdaIdx,
                         output int fallBad, output int riseSeen);
    useAlt = alt;
    holdLow = (stretch > 0);
    fallBad = 0;
    do @(negedge clk); while (!mFall);
    lowW = 0; sdaIdx = -1;
    while (mDrive) begin
      if (mSda) sdaIdx = lowW;
      lowW++;
      @(negedge clk);
      if (mDrive && mFall) fallBad++;
    end
    riseSeen = mRise ? 1 : 0;
    highW = 0;
    while (!mDrive) begin
      if (holdLow && highW == stretch) holdLow = 1'b0;
      highW++;
      @(negedge clk);
    end
    holdLow = 1'b0;
    useAlt = 1'b0;
  endtask

  task automatic runCheck(input string req, input bit alt, input int stretch);
    int lw, hw, si, fb, rs;
    bit hs = !alt;
    measure(alt, stretch, lw, hw, si, fb, rs);
    chk({req, " low width"},  lw, expLow(speedSel, hs));
    chk({req, " high width"}, hw, expHigh(speedSel, hs, stretch));
    chk({req, " R8 sda index"}, si, expSda(speedSel, hs));
    chk({req, " R6 fall strobe only first"}, fb, 0);
    chk({req, " R7 rise strobe"}, rs, 1);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) regMirror[i] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", int'(drvA), 0);
    chk("R1 strobes in reset", int'({riseA, fallA, sdaA}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 drive after reset", int'(drvA), 0);
    chk("R1 strobes after reset", int'({riseA, fallA, sdaA}), 0);

    // R5: reset counts of zero clamp to floor
    speedSel = 2'b01;
    turnOn();
    runCheck("R5 reset defaults", 1'b0, 0);
    turnOff();

    // directed programming
    wrReg(0, 10, 1); wrReg(1, 20, 1);
    wrReg(2, 8, 1);  wrReg(3, 15, 1);
    wrReg(4, 7, 1);  wrReg(5, 9, 1);
    wrReg(6, 3, 1);

    speedSel = 2'b01; turnOn(); runCheck("R2 standard", 1'b0, 0); turnOff();
    speedSel = 2'b10; turnOn(); runCheck("R3 fast", 1'b0, 0); turnOff();
    speedSel = 2'b00; turnOn(); runCheck("R3 code 00", 1'b0, 0); turnOff();
    speedSel = 2'b11; turnOn(); runCheck("R4 high speed", 1'b0, 0); turnOff();
    speedSel = 2'b11; turnOn(); runCheck("R4 fallback no hs", 1'b1, 0); turnOff();

    // R7: stretching by a target
    speedSel = 2'b01; turnOn(); runCheck("R7 stretch 5", 1'b0, 5); turnOff();
    turnOn(); runCheck("R7 stretch 1", 1'b0, 1); turnOff();

    // R8: hold beyond low phase is limited
    wrReg(6, 50, 1);
    turnOn(); runCheck("R8 long hold", 1'b0, 0); turnOff();
    wrReg(6, 0, 1);
    turnOn(); runCheck("R8 zero hold", 1'b0, 0); turnOff();

    // R5: small counts clamp
    wrReg(0, 2, 1); wrReg(1, 0, 1); wrReg(6, 9, 1);
    turnOn(); runCheck("R5 clamp", 1'b0, 0); turnOff();

    // R9: writes while enabled are dropped; address 7 is unused
    wrReg(0, 10, 1); wrReg(1, 20, 1); wrReg(6, 4, 1);
    wrReg(7, 3, 0);
    turnOn();
    wrReg(1, 30, 0);
    wrReg(0, 2, 0);
    runCheck("R9 write while enabled", 1'b0, 0);
    turnOff();
    turnOn(); runCheck("R9 after re-enable", 1'b0, 0); turnOff();

    // R10: disable in mid low phase
    turnOn();
    do @(negedge clk); while (!fallA);
    repeat (3) @(negedge clk);
    ctrlEnable = 1'b0;
    @(negedge clk);
    chk("R10 released next cycle", int'(drvA), 0);
    begin
      int stray = 0;
      for (int k = 0; k < 5; k++) begin
        if (drvA || riseA || fallA || sdaA) stray++;
        @(negedge clk);
      end
      chk("R10 quiet while off", stray, 0);
    end
    ctrlEnable = 1'b1;
    @(negedge clk);
    chk("R10 low on enable", int'(drvA), 1);
    chk("R10 fall strobe on enable", int'(fallA), 1);
    turnOff();

    // random mix over all speed codes
    for (int it = 0; it < 14; it++) begin
      int st;
      for (int a = 0; a < 7; a++) wrReg(a, int'($urandom_range(0, 40)), 1);
      speedSel = 2'($urandom_range(0, 3));
      st = int'($urandom_range(0, 4));
      turnOn();
      runCheck("R2 R3 R4 random", 1'b0, st);
      turnOff();
      if (speedSel == 2'b11) begin
        turnOn(); runCheck("R4 random fallback", 1'b1, 0); turnOff();
      end
    end

    finished = 1'b1;
    report();
    $finish;
  end

endmodule